// File: doc/BRIEF.md
# Accept-Aligned Record Buffer with 16-bit Word Readout

This block keeps recent pixel records in a circular store while a first-level trigger decides whether to keep them. Incoming data arrives as 32-bit slices on a valid strobe. Three slices describe one cell, and eight cells (24 slices) make one record. After the 24th slice of a record, the write position moves on to the next record slot. Slots that nobody asks for are simply written again later.

The accept input asks for the record that lies a programmed number of records behind the one being filled. This lets the stored data line up with the fixed latency of the trigger. The chosen slot is placed in a short queue of pending requests. A serializer takes requests from the queue and sends each record as 48 consecutive 16-bit words, with a valid strobe and a flag on the final word. If an accept arrives while the queue is full, it is dropped and a sticky overflow flag is raised.

The store has twice as many slots as the largest programmable depth. A requested record therefore stays intact while it waits in the queue and while it is being sent.

Top module: `accept_record_buffer`

## Requirements
- R1: After reset, out_valid, out_last and acc_overflow are 0. The first slice written goes to record slot 0, slice position 0.
- R2: Each cycle with in_valid high stores in_data as the next slice of the current record. After slice 23, the write position moves to slice 0 of the next slot, modulo 2*MAX_DEPTH slots. Cycles with in_valid low store nothing, whatever in_data holds.
- R3: An accept sampled at a clock edge requests the slot equal to (slot being filled before that edge) minus the effective depth, modulo 2*MAX_DEPTH. A depth of 1 therefore names the most recently completed record.
- R4: cfg_depth is clamped. A value of 0 acts as 1, and a value above MAX_DEPTH acts as MAX_DEPTH.
- R5: When the serializer is idle and no request is pending, an accept sampled at edge k makes word 0 appear after edge k+1. The record's 48 words then follow on 48 consecutive cycles, each with out_valid high.
- R6: Word w (0..47) equals bits [16*(w mod 2) +: 16] of the record's slice number floor(w/2), counted in arrival order. Cell c, slice s is arrival number 3c+s, so each cell starts at slice 0 and sends its low half first.
- R7: out_last is high on word 47 of each record and on no other word.
- R8: Accepts that arrive during a readout are served in arrival order. When a request is pending at word 47, the next record's word 0 follows in the very next cycle.
- R9: Up to 4 requests can wait behind the record being sent. An accept sampled while 4 are waiting is discarded, even if a request leaves the queue at that same edge. It sets acc_overflow, which stays 1 until reset.
- R10: A slot that is reused holds only the newest data. A record that was never requested is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 6 (DEPTH_W) | Programmed accept latency, in records |
| in_valid | input | 1 | A slice is present on in_data |
| in_data | input | 32 (SLICE_W) | Pixel slice |
| accept | input | 1 | Trigger accept, one request per cycle it is high |
| out_valid | output | 1 | out_data carries a record word |
| out_last | output | 1 | Final word of a record |
| out_data | output | 16 (OUT_W) | Serialized record word |
| acc_overflow | output | 1 | Sticky: an accept was dropped |

## Verification
An accept sampled at edge k is due as word 0 after edge k+1. Later words and the next queued record follow one per cycle. The overflow flag is due right after the edge that sampled the dropped accept. The bench drives inputs and samples outputs at the falling edge. Its model resolves each accept at the rising edge, using the queue occupancy from before that edge, just as the hardware does. The directed cases check the due cycle itself: out_valid must still be low one cycle after the accept and high one cycle later. They also check that three queued records form one unbroken run of 144 valid cycles. A falling-edge monitor compares every word and every out_last against the model's expected word for the slot it predicted.

// File: rtl/tab_pkg.sv
package tab_pkg;

   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_RUN  = 1'b1
   } ser_state_e;

   // Map a raw depth request onto the legal range 1..max_d.
   function automatic int clamp_depth(input int raw, input int max_d);
      if (raw < 1)
         return 1;
      else if (raw > max_d)
         return max_d;
      else
         return raw;
   endfunction

endpackage

// File: rtl/tab_record_store.sv
module tab_record_store #(
   parameter int SLICE_W    = 32,
   parameter int REC_SLICES = 24,
   parameter int NREC       = 64,
   localparam int REC_W     = $clog2(NREC),
   localparam int SL_W      = $clog2(REC_SLICES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SLICE_W-1:0] wr_data,
   output logic [REC_W-1:0]   wr_rec,
   input  logic [REC_W-1:0]   rd_rec,
   input  logic [SL_W-1:0]    rd_slice,
   output logic [SLICE_W-1:0] rd_data
);
   localparam int ADDR_W = $clog2(NREC * REC_SLICES);
   localparam logic [SL_W-1:0] SL_LAST = SL_W'(REC_SLICES - 1);

   logic [SLICE_W-1:0] mem [NREC*REC_SLICES];
   logic [SL_W-1:0]    slice_q;
   logic [REC_W-1:0]   rec_q;
   logic [ADDR_W-1:0]  wr_addr, rd_addr;

   assign wr_addr = ADDR_W'(rec_q) * ADDR_W'(REC_SLICES) + ADDR_W'(slice_q);
   assign rd_addr = ADDR_W'(rd_rec) * ADDR_W'(REC_SLICES) + ADDR_W'(rd_slice);
   assign wr_rec  = rec_q;
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slice_q <= '0;
         rec_q   <= '0;
      end else if (wr_en) begin
         if (slice_q == SL_LAST) begin
            slice_q <= '0;
            rec_q   <= rec_q + 1'b1;
         end else begin
            slice_q <= slice_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   // R2: the slice position never leaves the record
   a_r2_slice_range: assert property (@(posedge clk) disable iff (!rst_n)
      slice_q <= SL_LAST);

   // R2: the slot index moves only when a record is completed
   a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && slice_q == SL_LAST) |=> $stable(rec_q));

endmodule

// File: rtl/tab_accept_queue.sv
module tab_accept_queue #(
   parameter int PTR_W  = 6,
   parameter int QDEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PTR_W-1:0] push_slot,
   input  logic             pop,
   output logic [PTR_W-1:0] head_slot,
   output logic             nonempty,
   output logic             overflow
);
   localparam int QI_W  = $clog2(QDEPTH);
   localparam int CNT_W = $clog2(QDEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QDEPTH);
   localparam logic [QI_W-1:0]  QI_LAST  = QI_W'(QDEPTH - 1);

   logic [PTR_W-1:0] slot_q [QDEPTH];
   logic [QI_W-1:0]  wi_q, ri_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full, push_ok;

   assign full      = (cnt_q == CNT_FULL);
   assign push_ok   = push && !full;
   assign nonempty  = (cnt_q != '0);
   assign head_slot = slot_q[ri_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wi_q     <= '0;
         ri_q     <= '0;
         cnt_q    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push_ok)
            wi_q <= (wi_q == QI_LAST) ? '0 : wi_q + 1'b1;
         if (pop)
            ri_q <= (ri_q == QI_LAST) ? '0 : ri_q + 1'b1;
         case ({push_ok, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (push && full)
            overflow <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok)
         slot_q[wi_q] <= push_slot;
   end

   // R9: occupancy never exceeds the queue size
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   // R9: an accept meeting a full queue raises the flag
   a_r9_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      push && full |=> overflow);

   // R9: the flag is sticky
   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R8: the serializer only takes what is there
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nonempty);

endmodule

// File: rtl/tab_word_serializer.sv
module tab_word_serializer
   import tab_pkg::*;
#(
   parameter int SLICE_W    = 32,
   parameter int OUT_W      = 16,
   parameter int REC_SLICES = 24,
   parameter int PTR_W      = 6,
   localparam int SL_W      = $clog2(REC_SLICES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               q_nonempty,
   input  logic [PTR_W-1:0]   q_head,
   output logic               q_pop,
   output logic [PTR_W-1:0]   rd_rec,
   output logic [SL_W-1:0]    rd_slice,
   input  logic [SLICE_W-1:0] rd_data,
   output logic               out_valid,
   output logic               out_last,
   output logic [OUT_W-1:0]   out_data
);
   localparam int WPS       = SLICE_W / OUT_W;
   localparam int REC_WORDS = REC_SLICES * WPS;
   localparam int WIDX_W    = $clog2(REC_WORDS);
   localparam logic [WIDX_W-1:0] W_LAST = WIDX_W'(REC_WORDS - 1);

   ser_state_e        state_q;
   logic [WIDX_W-1:0] widx_q;
   logic [PTR_W-1:0]  rec_q;
   logic              at_last;

   assign at_last   = (state_q == SER_RUN) && (widx_q == W_LAST);
   assign q_pop     = q_nonempty && ((state_q == SER_IDLE) || at_last);
   assign out_valid = (state_q == SER_RUN);
   assign out_last  = at_last;
   assign rd_rec    = rec_q;

   generate
      if (WPS == 1) begin : g_full_slice
         assign rd_slice = SL_W'(widx_q);
         assign out_data = rd_data;
      end else begin : g_split_slice
         localparam int PART_W = $clog2(WPS);
         logic [PART_W-1:0] part;
         assign part     = PART_W'(widx_q % WIDX_W'(WPS));
         assign rd_slice = SL_W'(widx_q / WIDX_W'(WPS));
         assign out_data = rd_data[int'(part)*OUT_W +: OUT_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SER_IDLE;
         widx_q  <= '0;
         rec_q   <= '0;
      end else if (q_pop) begin
         state_q <= SER_RUN;
         widx_q  <= '0;
         rec_q   <= q_head;
      end else if (at_last) begin
         state_q <= SER_IDLE;
         widx_q  <= '0;
      end else if (state_q == SER_RUN) begin
         widx_q <= widx_q + 1'b1;
      end
   end

   // R7: the last flag only travels with a valid word
   a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R5: a record, once started, is sent without gaps
   a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |=> out_valid);

   // R5: a pending request starts a readout on the next cycle
   a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && q_nonempty |=> out_valid && !out_last);

   // R8: a pending request follows the last word directly
   a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      out_last && q_nonempty |=> out_valid);

endmodule

// File: rtl/accept_record_buffer.sv
module accept_record_buffer
   import tab_pkg::*;
#(
   parameter int SLICE_W        = 32,
   parameter int OUT_W          = 16,
   parameter int SLICES_PER_CELL = 3,
   parameter int CELLS          = 8,
   parameter int MAX_DEPTH      = 32,
   parameter int QDEPTH         = 4,
   localparam int DEPTH_W       = $clog2(MAX_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] cfg_depth,
   input  logic               in_valid,
   input  logic [SLICE_W-1:0] in_data,
   input  logic               accept,
   output logic               out_valid,
   output logic               out_last,
   output logic [OUT_W-1:0]   out_data,
   output logic               acc_overflow
);
   localparam int REC_SLICES = SLICES_PER_CELL * CELLS;
   localparam int NREC       = 2 * MAX_DEPTH;
   localparam int PTR_W      = $clog2(NREC);
   localparam int SL_W       = $clog2(REC_SLICES);

   generate
      if (SLICE_W % OUT_W != 0) begin : g_bad_width
         $error("SLICE_W must be a multiple of OUT_W");
      end
      if ((MAX_DEPTH < 1) || ((MAX_DEPTH & (MAX_DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("MAX_DEPTH must be a power of two");
      end
      if ((QDEPTH < 2) || ((QDEPTH & (QDEPTH - 1)) != 0)) begin : g_bad_queue
         $error("QDEPTH must be a power of two of at least 2");
      end
      if (REC_SLICES < 2) begin : g_bad_record
         $error("a record needs at least two slices");
      end
   endgenerate

   logic [PTR_W-1:0]   wr_rec, req_slot, head_slot, rd_rec;
   logic [SL_W-1:0]    rd_slice;
   logic [SLICE_W-1:0] rd_data;
   logic               q_nonempty, q_pop;
   int                 eff_depth;

   assign eff_depth = clamp_depth(int'(cfg_depth), MAX_DEPTH);
   assign req_slot  = wr_rec - PTR_W'(eff_depth);

   tab_record_store #(
      .SLICE_W   (SLICE_W),
      .REC_SLICES(REC_SLICES),
      .NREC      (NREC)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_data (in_data),
      .wr_rec  (wr_rec),
      .rd_rec  (rd_rec),
      .rd_slice(rd_slice),
      .rd_data (rd_data)
   );

   tab_accept_queue #(
      .PTR_W (PTR_W),
      .QDEPTH(QDEPTH)
   ) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept),
      .push_slot(req_slot),
      .pop      (q_pop),
      .head_slot(head_slot),
      .nonempty (q_nonempty),
      .overflow (acc_overflow)
   );

   tab_word_serializer #(
      .SLICE_W   (SLICE_W),
      .OUT_W     (OUT_W),
      .REC_SLICES(REC_SLICES),
      .PTR_W     (PTR_W)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_nonempty(q_nonempty),
      .q_head    (head_slot),
      .q_pop     (q_pop),
      .rd_rec    (rd_rec),
      .rd_slice  (rd_slice),
      .rd_data   (rd_data),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_data  (out_data)
   );

   // R3: the requested slot is never the one being filled
   a_r3_slot_behind: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> req_slot != wr_rec);

endmodule

// File: tb/sim_accept_record_buffer.sv
module sim_accept_record_buffer;
   localparam int CLK_PERIOD = 10;
   localparam int NREC = 64;
   localparam int RS   = 24;
   localparam int QD   = 4;
   localparam int MAXD = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_depth = 6'd1;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        accept = 1'b0;
   logic        out_valid, out_last, acc_overflow;
   logic [15:0] out_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] mdl [NREC*RS];
   int wrec_m = 0;
   int slice_m = 0;
   int expq[$];
   bit exp_ovf = 0;
   int w_m = 0;
   int cur_slot = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   accept_record_buffer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .in_valid(in_valid),
      .in_data(in_data), .accept(accept), .out_valid(out_valid),
      .out_last(out_last), .out_data(out_data), .acc_overflow(acc_overflow)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int clampd(input int raw);
      if (raw < 1) return 1;
      if (raw > MAXD) return MAXD;
      return raw;
   endfunction

   function automatic logic [15:0] exp_word(input int slot, input int w);
      logic [31:0] s;
      s = mdl[slot*RS + w/2];
      return (w % 2 == 1) ? s[31:16] : s[15:0];
   endfunction

   // One cycle: inputs set after a falling edge, model updated at the rising edge.
   task automatic step(input logic v, input logic [31:0] d, input logic a);
      in_valid = v;
      in_data  = d;
      accept   = a;
      @(posedge clk);
      if (a) begin
         int slot;
         slot = (wrec_m - clampd(int'(cfg_depth)) + NREC) % NREC;
         if (expq.size() >= QD) exp_ovf = 1;
         else expq.push_back(slot);
      end
      if (v) begin
         mdl[wrec_m*RS + slice_m] = d;
         slice_m++;
         if (slice_m == RS) begin
            slice_m = 0;
            wrec_m = (wrec_m + 1) % NREC;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      accept   = 1'b0;
      in_data  = $urandom;
   endtask

   // R2: idle cycles carry junk data that must not be stored
   task automatic write_records(input int n);
      for (int r = 0; r < n; r++) begin
         for (int s = 0; s < RS; s++) begin
            step(1'b1, $urandom, 1'b0);
            if ($urandom_range(0, 3) == 0) step(1'b0, $urandom, 1'b0);
         end
      end
   endtask

   task automatic drain();
      int guard = 0;
      while ((expq.size() != 0 || out_valid) && guard < 2000) begin
         step(1'b0, $urandom, 1'b0);
         guard++;
      end
   endtask

   // Monitor: every word against the model (R2 R3 R6 R7 R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (w_m == 0) begin
               if (expq.size() == 0) begin
                  chk(1'b0, "R10 unrequested record sent", 1, 0);
                  cur_slot = -1;
               end else begin
                  cur_slot = expq.pop_front();
               end
            end
            if (cur_slot >= 0)
               chk(out_data == exp_word(cur_slot, w_m), "R2 R3 R6 R10 word data",
                   out_data, exp_word(cur_slot, w_m));
            chk(out_last == (w_m == 47), "R7 last flag", out_last, (w_m == 47));
            w_m = (w_m == 47) ? 0 : w_m + 1;
         end else if (w_m != 0) begin
            chk(1'b0, "R5 gap inside record", w_m, 48);
            w_m = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int run;
      void'($urandom(32'd1913));
      for (int i = 0; i < NREC*RS; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid == 0, "R1 out_valid", out_valid, 0);
      chk(out_last == 0, "R1 out_last", out_last, 0);
      chk(acc_overflow == 0, "R1 acc_overflow", acc_overflow, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R5: three records, depth 1 reads slot 2; depth 3 reads slot 0
      write_records(3);
      cfg_depth = 6'd1;
      step(1'b0, $urandom, 1'b1);
      chk(out_valid == 0, "R5 not yet valid one cycle after accept", out_valid, 0);
      step(1'b0, $urandom, 1'b0);
      chk(out_valid == 1, "R5 word 0 two cycles after accept", out_valid, 1);
      drain();
      cfg_depth = 6'd3;
      step(1'b0, $urandom, 1'b1);
      drain();

      // R4: clamping of depth
      write_records(40);
      cfg_depth = 6'd0;
      step(1'b0, $urandom, 1'b1);
      drain();
      cfg_depth = 6'd63;
      step(1'b0, $urandom, 1'b1);
      drain();
      cfg_depth = 6'd32;
      step(1'b0, $urandom, 1'b1);
      drain();

      // R8: three accepts give one unbroken run of 144 words
      cfg_depth = 6'd2;
      run = 0;
      for (int i = 0; i < 3; i++) begin
         step(1'b0, $urandom, 1'b1);
         if (out_valid) run++;
      end
      for (int i = 0; i < 400; i++) begin
         step(1'b0, $urandom, 1'b0);
         if (out_valid) run++;
         else if (run > 0) break;
      end
      chk(run == 144, "R8 back-to-back run length", run, 144);
      drain();

      // R9: six accepts in a row, the sixth meets a full queue
      cfg_depth = 6'd5;
      for (int i = 0; i < 6; i++) step(1'b0, $urandom, 1'b1);
      chk(exp_ovf == 1, "R9 model predicts drop", exp_ovf, 1);
      chk(acc_overflow == 1, "R9 overflow raised", acc_overflow, 1);
      chk(expq.size() == 4, "R9 four records still pending", expq.size(), 4);
      drain();
      chk(acc_overflow == 1, "R9 overflow sticky", acc_overflow, 1);

      // R10: slots reused after wrap hold the newest data
      write_records(30);
      cfg_depth = 6'd1;
      step(1'b0, $urandom, 1'b1);
      cfg_depth = 6'd20;
      step(1'b0, $urandom, 1'b1);
      drain();

      // Random phase: mixed writes, accepts and depths
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) < 2) cfg_depth = 6'($urandom_range(0, 40));
         step($urandom_range(0, 9) < 7, $urandom, $urandom_range(0, 99) < 4);
      end
      drain();
      chk(expq.size() == 0, "R8 all requests served", expq.size(), 0);
      chk(acc_overflow == 1, "R9 flag still set", acc_overflow, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule